// File: doc/BRIEF.md
# Bus Monitor Packet Recorder

This block sits behind a serial-bus word decoder and records the traffic it sees into a circular region of RAM as a telemetry data packet. Each incoming 16-bit word arrives as a one-cycle strobe. The strobe carries a good/bad tag from the decoder, a flag for the first word of a message and a flag for the last word. The block writes through a single synchronous RAM write port and never reads memory back.

For each message, the block writes a status word, three time-tag words and then the bus words. The status word goes into a slot reserved when the message opens, and is written only once the message closes. A message closes in one of four ways: on its last word, on a bad word, on a response time-out, or on a packet-finalize strobe. A five-bit control register sets the recording policy at run time:

- whether a bad word aborts the message or is kept;
- whether a header slot and a trailer are produced around the packet;
- whether the extra status flags are filled in;
- whether a 16-bit body checksum goes into the trailer;
- whether recording is enabled at all.

A free-running 48-bit counter supplies the time tag.

Words must arrive at least 8 clock cycles apart. A finalize strobe must not be raised while the write sequence of a previous finalize is still running.

Top module: `bm_pkt_rec`

## Requirements
- R1: The control register `cfg_rdata` resets to 0 and loads `cfg_wdata` on the clock after `cfg_we`. Its bit meanings are:
  - bit 4: keep bad words;
  - bit 3: body only;
  - bit 2: extended flags;
  - bit 1: checksum enable;
  - bit 0: recording off.
- R2: A 48-bit time tag counts clock cycles from 0 after reset. At the first word of a message it is captured and written as three words, lowest 16 bits first.
- R3: A message opens only on a good word with `word_first`=1. Its layout is: the status word in the reserved slot, then time tag bits [15:0], [31:16] and [47:32], then the bus words in arrival order. If the first word arrives in cycle k, its writes are visible in cycles k+1 to k+4. Each later word arriving in cycle k is written in cycle k+1.
- R4: A word with `word_last`=1 closes the message. The status word is written in the cycle after that word's data write. Its fields are:
  - [15]: time-out;
  - [14]: bad word seen;
  - [13]: aborted by a bad word (extended);
  - [12]: closed by finalize (extended);
  - [11:8]: zero;
  - [7:0]: number of bus words stored.
- R5: With bit 4 at 0, a bad word inside a message is not written. The message closes with bits 14 and 13 set, and its status word is visible 2 cycles after the bad word. Words without `word_first` are then ignored.
- R6: With bit 4 at 1, a bad word is written like any other word, bit 14 of the status word is set, and the message continues.
- R7: If an open message receives no word for TMO_CYC cycles after its last accepted word, it closes with bit 15 set. The status word is visible TMO_CYC+2 cycles after that word.
- R8: With bit 3 at 0, a finalize writes the header and the trailer, then the next packet begins:
  - the header holds the count of body words and goes into the slot reserved when the packet began;
  - the trailer goes to the address after the last body word;
  - the next packet reserves its header slot right after the trailer.
- R9: With bit 1 at 1 and bit 3 at 0, the trailer holds the modulo-2^16 sum of every body word of the packet (status, time-tag and bus words). Otherwise the trailer is 0. The sum restarts with each packet.
- R10: With bit 3 at 1, no header or trailer is ever written. A finalize only closes an open message and restarts the count and the sum.
- R11: Status bits 13 and 12 are written only when bit 2 is 1. Otherwise they are 0.
- R12: With bit 0 at 1, bus words are ignored and cause no RAM write.
- R13: Every RAM write address lies in START_ADDR..END_ADDR, and the address after END_ADDR is START_ADDR.
- R14: A finalize that meets an open message closes that message first, with bit 12 set, and then writes the header and the trailer. A finalize strobe in the same cycle as a word is served after that word's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write value |
| cfg_rdata | output | 5 | Control register contents |
| word_vld | input | 1 | Decoded bus word strobe |
| word_data | input | 16 | Decoded bus word |
| word_ok | input | 1 | Word decoded without error |
| word_first | input | 1 | Word starts a message |
| word_last | input | 1 | Word ends a message |
| pkt_final | input | 1 | Finalize the current packet |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 16 | RAM write data |

## Verification
A finalize strobe can land in the same cycle as a bus word. It can also land while a message is still open, so that a message close and the packet's header and trailer writes compete for the one write port. The bench provokes both cases: it raises `pkt_final` together with a middle word of a message, and again about nine cycles after a first word. The bench model predicts the cycle, address and data of every write. It expects the following order: the word's data, then the status word with bit 12 set, then the header and then the trailer. The checksum must include the late status word.

// File: rtl/bmr_pkg.sv
`timescale 1ns/1ps
package bmr_pkg;
  localparam int TT_W = 48;
  localparam int WD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TT1, ST_TT2, ST_DAT, ST_BSW, ST_HDR, ST_TRL
  } seq_t;

  // control bit positions
  localparam int CB_KEEP = 4;
  localparam int CB_BODY = 3;
  localparam int CB_XFLG = 2;
  localparam int CB_CKEN = 1;
  localparam int CB_OFF  = 0;

  function automatic logic [WD_W-1:0] sum16(input logic [WD_W-1:0] a, input logic [WD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WD_W-1:0] pack_status(input logic tmo, input logic bad, input logic ext,
                                                  input logic abrt, input logic fin, input logic [7:0] n);
    return {tmo, bad, ext & abrt, ext & fin, 4'b0000, n};
  endfunction
endpackage

// File: rtl/bmr_cfg_reg.sv
`timescale 1ns/1ps
module bmr_cfg_reg #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> q == $past(q));
endmodule

// File: rtl/bmr_timetag.sv
`timescale 1ns/1ps
module bmr_timetag #(
  parameter int TW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tt
);
  always_ff @(posedge clk) begin
    if (!rst_n) tt <= '0;
    else        tt <= tt + TW'(1);
  end

  assert_tt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tt == $past(tt) + TW'(1));
endmodule

// File: rtl/bmr_tmo.sv
`timescale 1ns/1ps
module bmr_tmo #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || kick) cnt <= '0;
    else if (cnt != LAST)       cnt <= cnt + CW'(1);
  end

  assign hit = run && (cnt == LAST);

  assert_tmo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !hit);
endmodule

// File: rtl/bm_pkt_rec.sv
`timescale 1ns/1ps
module bm_pkt_rec
  import bmr_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int START_ADDR = 0,
  parameter int END_ADDR   = 1023,
  parameter int TMO_CYC    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_wdata,
  output logic [4:0]        cfg_rdata,
  input  logic              word_vld,
  input  logic [15:0]       word_data,
  input  logic              word_ok,
  input  logic              word_first,
  input  logic              word_last,
  input  logic              pkt_final,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [15:0]       ram_wdata
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(END_ADDR);

  function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] a);
    return (a == A_HI) ? A_LO : a + ADDR_W'(1);
  endfunction

  logic [TT_W-1:0] tt;
  logic            tmo_hit;

  bmr_cfg_reg #(.CW(5)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata));

  bmr_timetag #(.TW(TT_W)) u_tt (.clk(clk), .rst_n(rst_n), .tt(tt));

  wire keep_bad = cfg_rdata[CB_KEEP];
  wire body_only = cfg_rdata[CB_BODY];
  wire xflg = cfg_rdata[CB_XFLG];
  wire ck_en = cfg_rdata[CB_CKEN];
  wire rec_en = !cfg_rdata[CB_OFF];

  seq_t              st;
  logic              open_q, fin_pend, last_l, ram_body;
  logic              f_tmo, f_bad, f_abrt, f_fin;
  logic [ADDR_W-1:0] wp, pkt_base, bsw_addr;
  logic [31:0]       tt_hi;
  logic [15:0]       dat_l, cks, bcnt;
  logic [7:0]        wcnt;

  // named events
  wire idle = (st == ST_IDLE);
  wire w_take = idle && rec_en && word_vld;
  wire w_open = w_take && !open_q && word_first && word_ok;
  wire w_more = w_take && open_q && (word_ok || keep_bad);
  wire w_stop = w_take && open_q && !word_ok && !keep_bad;
  wire to_fire = idle && open_q && !w_take && tmo_hit;
  wire fin_go = idle && !w_take && !to_fire && fin_pend;
  wire kick = w_open || w_more;

  bmr_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(open_q), .kick(kick), .hit(tmo_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; open_q <= 1'b0; fin_pend <= 1'b0; last_l <= 1'b0;
      f_tmo <= 1'b0; f_bad <= 1'b0; f_abrt <= 1'b0; f_fin <= 1'b0;
      wp <= adv(A_LO); pkt_base <= A_LO; bsw_addr <= A_LO;
      tt_hi <= '0; dat_l <= '0; cks <= '0; bcnt <= '0; wcnt <= '0;
      ram_we <= 1'b0; ram_body <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
    end else begin
      ram_we   <= 1'b0;
      ram_body <= 1'b0;
      if (ram_we && ram_body) begin
        cks  <= sum16(cks, ram_wdata);
        bcnt <= bcnt + 16'd1;
      end
      fin_pend <= fin_pend | pkt_final;
      case (st)
        ST_IDLE: begin
          if (w_open) begin
            open_q <= 1'b1; bsw_addr <= wp; tt_hi <= tt[47:16];
            dat_l <= word_data; last_l <= word_last; wcnt <= 8'd1;
            f_tmo <= 1'b0; f_bad <= 1'b0; f_abrt <= 1'b0; f_fin <= 1'b0;
            ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= adv(wp); ram_wdata <= tt[15:0];
            wp <= adv(adv(wp));
            st <= ST_TT1;
          end else if (w_more) begin
            ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= wp; ram_wdata <= word_data;
            wp <= adv(wp);
            wcnt <= wcnt + 8'd1;
            if (!word_ok) f_bad <= 1'b1;
            if (word_last) st <= ST_BSW;
          end else if (w_stop) begin
            f_bad <= 1'b1; f_abrt <= 1'b1; st <= ST_BSW;
          end else if (to_fire) begin
            f_tmo <= 1'b1; st <= ST_BSW;
          end else if (fin_go) begin
            if (open_q) begin
              f_fin <= 1'b1; st <= ST_BSW;
            end else if (!body_only) begin
              st <= ST_HDR;
            end else begin
              fin_pend <= pkt_final; cks <= '0; bcnt <= '0;
            end
          end
        end
        ST_TT1: begin
          ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= wp; ram_wdata <= tt_hi[15:0];
          wp <= adv(wp); st <= ST_TT2;
        end
        ST_TT2: begin
          ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= wp; ram_wdata <= tt_hi[31:16];
          wp <= adv(wp); st <= ST_DAT;
        end
        ST_DAT: begin
          ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= wp; ram_wdata <= dat_l;
          wp <= adv(wp); st <= last_l ? ST_BSW : ST_IDLE;
        end
        ST_BSW: begin
          ram_we <= 1'b1; ram_body <= 1'b1; ram_addr <= bsw_addr;
          ram_wdata <= pack_status(f_tmo, f_bad, xflg, f_abrt, f_fin, wcnt);
          open_q <= 1'b0; st <= ST_IDLE;
        end
        ST_HDR: begin
          ram_we <= 1'b1; ram_addr <= pkt_base; ram_wdata <= bcnt; st <= ST_TRL;
        end
        ST_TRL: begin
          ram_we <= 1'b1; ram_addr <= wp; ram_wdata <= ck_en ? cks : 16'd0;
          pkt_base <= adv(wp); wp <= adv(adv(wp));
          cks <= '0; bcnt <= '0; fin_pend <= pkt_final;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_addr_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (int'(ram_addr) >= START_ADDR) && (int'(ram_addr) <= END_ADDR));

  assert_stop_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_stop |=> !ram_we);

  assert_frame_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ram_body) |-> !$past(body_only));

  assert_open_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(word_first && word_ok && word_vld));
endmodule

// File: tb/sim_bm_pkt_rec.sv
`timescale 1ns/1ps
module sim_bm_pkt_rec;
  localparam int AW = 6;
  localparam int SA = 4;
  localparam int EA = 23;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic word_vld = 1'b0, word_ok = 1'b0, word_first = 1'b0, word_last = 1'b0, pkt_final = 1'b0;
  logic [15:0] word_data = '0;
  logic ram_we;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_wdata;

  always #2 clk = ~clk;

  bm_pkt_rec #(.ADDR_W(AW), .START_ADDR(SA), .END_ADDR(EA), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .word_vld(word_vld), .word_data(word_data), .word_ok(word_ok), .word_first(word_first),
    .word_last(word_last), .pkt_final(pkt_final),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  int n_cmp = 0;
  int n_bad = 0;
  int writes_seen = 0;
  bit done = 1'b0;

  // expected write stream
  int          q_cyc[$];
  int          q_adr[$];
  logic [15:0] q_dat[$];
  string       q_req[$];

  // behavioural model state
  int cyc = 0;
  logic [47:0] tt_m;
  logic [4:0] cfg_m;
  bit open_m, fin_m, m_tmo, m_bad, m_abrt, m_fin;
  int wp_m, base_m, bsw_m, wcnt_m, lw, free_at;
  logic [15:0] cks_m, bcnt_m;

  function automatic int nx(input int a);
    return (a == EA) ? SA : a + 1;
  endfunction

  task automatic push(input int c, input int a, input logic [15:0] d, input string r, input bit body);
    q_cyc.push_back(c);
    q_adr.push_back(a);
    q_dat.push_back(d);
    q_req.push_back((a == SA) ? {r, " R13"} : r);
    if (body) begin
      cks_m  = cks_m + d;
      bcnt_m = bcnt_m + 16'd1;
    end
  endtask

  task automatic close_msg(input int c);
    logic [15:0] s;
    string r;
    s = {m_tmo, m_bad, cfg_m[2] & m_abrt, cfg_m[2] & m_fin, 4'b0000, 8'(wcnt_m)};
    r = m_tmo ? "R7" : m_abrt ? "R5 R11" : m_fin ? "R14 R11" : m_bad ? "R6" : "R4";
    push(c, bsw_m, s, r, 1'b1);
    open_m = 1'b0;
  endtask

  always @(posedge clk) begin
    int k;
    logic [47:0] cap;
    bit idle, take;
    k = cyc;
    if (!rst_n) begin
      tt_m = '0; cfg_m = '0; open_m = 0; fin_m = 0;
      m_tmo = 0; m_bad = 0; m_abrt = 0; m_fin = 0;
      wp_m = SA; base_m = SA; bsw_m = SA; wcnt_m = 0; lw = 0; free_at = 0;
      cks_m = '0; bcnt_m = '0;
    end else begin
      cap = tt_m;
      tt_m = tt_m + 48'd1;
      idle = (k >= free_at);
      take = idle && !cfg_m[0] && word_vld;
      if (take && !open_m && word_first && word_ok) begin
        open_m = 1; m_tmo = 0; m_bad = 0; m_abrt = 0; m_fin = 0;
        wp_m = nx(wp_m); bsw_m = wp_m;
        wp_m = nx(wp_m); push(k + 1, wp_m, cap[15:0], "R2", 1'b1);
        wp_m = nx(wp_m); push(k + 2, wp_m, cap[31:16], "R2", 1'b1);
        wp_m = nx(wp_m); push(k + 3, wp_m, cap[47:32], "R2", 1'b1);
        wp_m = nx(wp_m); push(k + 4, wp_m, word_data, "R3", 1'b1);
        wcnt_m = 1; lw = k;
        if (word_last) begin close_msg(k + 5); free_at = k + 5; end
        else free_at = k + 4;
      end else if (take && open_m) begin
        if (word_ok || cfg_m[4]) begin
          wp_m = nx(wp_m);
          push(k + 1, wp_m, word_data, word_ok ? "R3" : "R6", 1'b1);
          wcnt_m = wcnt_m + 1; lw = k;
          if (!word_ok) m_bad = 1;
          if (word_last) begin close_msg(k + 2); free_at = k + 2; end
          else free_at = k + 1;
        end else begin
          m_bad = 1; m_abrt = 1;
          close_msg(k + 2); free_at = k + 2;
        end
      end else if (take) begin
        // ignored word outside a message
      end else if (idle && open_m && (k - lw) == TMO) begin
        m_tmo = 1; close_msg(k + 2); free_at = k + 2;
      end else if (idle && fin_m) begin
        if (open_m) begin
          m_fin = 1; close_msg(k + 2); free_at = k + 2;
        end else if (!cfg_m[3]) begin
          push(k + 2, base_m, bcnt_m, "R8", 1'b0);
          wp_m = nx(wp_m);
          push(k + 3, wp_m, cfg_m[1] ? cks_m : 16'd0, "R9", 1'b0);
          wp_m = nx(wp_m); base_m = wp_m;
          cks_m = '0; bcnt_m = '0; fin_m = 0; free_at = k + 3;
        end else begin
          cks_m = '0; bcnt_m = '0; fin_m = 0;
        end
      end
      fin_m = fin_m | pkt_final;
      if (cfg_we) cfg_m = cfg_wdata;
    end
    cyc = cyc + 1;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        writes_seen++;
        n_cmp++;
        if (q_cyc.size() == 0) begin
          n_bad++;
          $display("FAIL R3 unexpected write cyc=%0d: actual addr=%0d data=%h expected none",
                   cyc, ram_addr, ram_wdata);
        end else if (q_cyc[0] != cyc || int'(ram_addr) != q_adr[0] || ram_wdata != q_dat[0]) begin
          n_bad++;
          $display("FAIL %s write: actual cyc=%0d addr=%0d data=%h expected cyc=%0d addr=%0d data=%h",
                   q_req[0], cyc, ram_addr, ram_wdata, q_cyc[0], q_adr[0], q_dat[0]);
          void'(q_cyc.pop_front()); void'(q_adr.pop_front());
          void'(q_dat.pop_front()); void'(q_req.pop_front());
        end else begin
          void'(q_cyc.pop_front()); void'(q_adr.pop_front());
          void'(q_dat.pop_front()); void'(q_req.pop_front());
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s missing write: actual none at cyc=%0d expected addr=%0d data=%h",
                 q_req[0], cyc, q_adr[0], q_dat[0]);
        void'(q_cyc.pop_front()); void'(q_adr.pop_front());
        void'(q_dat.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [4:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    idle_cycles(2);
  endtask

  task automatic send(input logic [15:0] d, input bit ok, input bit first, input bit last,
                      input bit fin, input int gap);
    @(negedge clk);
    word_vld = 1'b1; word_data = d; word_ok = ok; word_first = first; word_last = last;
    pkt_final = fin;
    @(negedge clk);
    word_vld = 1'b0; word_ok = 1'b0; word_first = 1'b0; word_last = 1'b0; pkt_final = 1'b0;
    idle_cycles(gap);
  endtask

  task automatic finalize(input int gap);
    @(negedge clk); pkt_final = 1'b1;
    @(negedge clk); pkt_final = 1'b0;
    idle_cycles(gap);
  endtask

  task automatic check(input bit cond, input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  initial begin
    int ws;
    repeat (4) @(negedge clk);
    check(cfg_rdata == 5'd0, "R1", "cfg after reset", cfg_rdata, 0);
    check(ram_we == 1'b0, "R1", "no write in reset", ram_we, 0);
    rst_n = 1'b1;
    idle_cycles(2);

    // R1 readback; R8/R9 framed packet with checksum
    set_cfg(5'b00010);
    check(cfg_rdata == 5'b00010, "R1", "cfg readback", cfg_rdata, 2);
    send(16'h1234, 1, 1, 0, 0, 8);
    send(16'hABCD, 1, 0, 0, 0, 8);
    send(16'hFFFF, 1, 0, 1, 0, 8);
    send(16'h0042, 1, 1, 1, 0, 8);
    finalize(10);

    // R5 stop mode with extended flags, then an ignored word, then a new message
    set_cfg(5'b00110);
    send(16'h1111, 1, 1, 0, 0, 8);
    send(16'hDEAD, 0, 0, 0, 0, 8);
    send(16'h2222, 1, 0, 1, 0, 8);
    send(16'h3333, 1, 1, 1, 0, 8);
    // R11 stop mode without extended flags
    set_cfg(5'b00010);
    send(16'h4444, 1, 1, 0, 0, 8);
    send(16'hBEEF, 0, 0, 0, 0, 8);

    // R6 continue mode
    set_cfg(5'b10110);
    send(16'h5555, 1, 1, 0, 0, 8);
    send(16'hBAD0, 0, 0, 0, 0, 8);
    send(16'h6666, 1, 0, 1, 0, 8);

    // R7 time-out
    send(16'h7777, 1, 1, 0, 0, 22);

    // R14 finalize with a message open
    send(16'h8888, 1, 1, 0, 0, 8);
    finalize(12);

    // R14 finalize in the same cycle as a middle word
    send(16'h9999, 1, 1, 0, 0, 8);
    send(16'hAAAA, 1, 0, 0, 1, 14);

    // R9 checksum disabled: trailer zero
    set_cfg(5'b00100);
    send(16'hC001, 1, 1, 1, 0, 8);
    finalize(10);

    // R10 body-only
    set_cfg(5'b01010);
    send(16'hD00D, 1, 1, 0, 0, 8);
    send(16'hD00E, 1, 0, 1, 0, 8);
    idle_cycles(4);
    ws = writes_seen;
    finalize(10);
    check(writes_seen == ws, "R10", "writes on body-only finalize", writes_seen - ws, 0);

    // R12 recording off
    set_cfg(5'b00001);
    ws = writes_seen;
    send(16'hE001, 1, 1, 0, 0, 8);
    send(16'hE002, 1, 0, 1, 0, 8);
    check(writes_seen == ws, "R12", "writes with recording off", writes_seen - ws, 0);
    check(q_cyc.size() == 0, "R12", "pending expected writes", q_cyc.size(), 0);

    // back on: wrap through the stack again
    set_cfg(5'b00010);
    send(16'hF001, 1, 1, 0, 0, 8);
    send(16'hF002, 1, 0, 1, 0, 8);
    finalize(10);

    idle_cycles(20);
    check(q_cyc.size() == 0, "R3", "undelivered writes at end", q_cyc.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule